// File: doc/BRIEF.md
# Power-Up Configuration Byte Fetch Sequencer

This block sits between the board's raw reset input and the processor's reset line. When the raw reset is released, it keeps the processor in reset. It then performs one read from the battery-backed RAM inside a real-time-clock chip whose address and data share a single 8-bit bus. The byte it reads holds a boot-time selection, such as which of several boot memory banks to use. The block publishes that byte with a valid flag, and only then lets the processor run.

The block has no output drivers on the shared bus. It relies on the idle bus reading all ones. During the address phase the clock chip latches 0xFF as the address. The chip decodes only seven address bits, so 0xFF selects location 0x7F, the last byte of the RAM, which holds the configuration. During the data phase the chip drives that byte, and the block samples it on the final clock edge of the read strobe.

The control flow is a seven-state machine:

- **ST_IDLE_RESET**: reset and synchronisation.
- **ST_ADDR_STROBE**: the address strobe is held for `STROBE_W` clocks.
- **ST_ADDR_HOLD**: a quiet gap of `GAP_W` clocks.
- **ST_DATA_STROBE**: the read strobe is held for `STROBE_W` clocks, and the bus is sampled on its last edge.
- **ST_DATA_SAMPLE**: one settling clock.
- **ST_RELEASE**: valid is raised while the processor reset is still held.
- **ST_RUN**: the processor reset is released.

The transitions run in that order, and each strobe or gap state leaves when its down-counter reaches zero. A low level on the raw reset sends the machine back to ST_IDLE_RESET from any state, at any time.

Top module: `cfg_fetch_seq`

## Requirements
- R1: While `rst_in_n` is low, and for `SYNC_STAGES` clock edges after it rises, the outputs are held at their reset values: `cpu_rst_n`=0, `rtc_cs_n`=`rtc_as_n`=`rtc_rd_n`=1, `cfg_vld`=0 and `cfg_q`=0x00.
- R2: The first active phase drives `rtc_cs_n` and `rtc_as_n` low for exactly `STROBE_W` cycles, with `rtc_rd_n` high. The idle bus value 0xFF, masked to 7 bits, addresses location 0x7F.
- R3: After the address strobe, all three chip controls stay high for exactly `GAP_W` cycles.
- R4: The data phase then drives `rtc_cs_n` and `rtc_rd_n` low for exactly `STROBE_W` cycles, with `rtc_as_n` high.
- R5: After the fetch, `cfg_q` equals the `bus_in` value present at the last rising edge of the data strobe. Bus values at every other time have no effect.
- R6: One settling cycle follows the data strobe. In it, all controls are high, `cfg_vld`=0 and `cfg_q` still reads 0x00. `cfg_q` reads 0x00 whenever `cfg_vld` is low.
- R7: `cfg_vld` rises, with `cfg_q` already loaded, exactly one cycle before `cpu_rst_n` rises.
- R8: Once running, `cpu_rst_n`=1 and `cfg_vld`=1, all chip controls stay high, and `cfg_q` stays constant whatever `bus_in` does, until the next reset.
- R9: Driving `rst_in_n` low in any state at once returns every output to its R1 value. Releasing it repeats the complete sequence.
- R10: `rtc_as_n` and `rtc_rd_n` are never low together, and either one being low implies `rtc_cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_in_n | input | 1 | Raw board reset, active low, asynchronous assertion |
| bus_in | input | 8 | Shared RTC address/data bus, observed only |
| cpu_rst_n | output | 1 | Processor reset, active low |
| rtc_cs_n | output | 1 | RTC chip select, active low |
| rtc_as_n | output | 1 | RTC address strobe, active low |
| rtc_rd_n | output | 1 | RTC read/data strobe, active low |
| cfg_q | output | 8 | Fetched configuration byte |
| cfg_vld | output | 1 | Configuration byte valid |

## Verification
Sixteen byte patterns are fetched to completion, including 0x00, 0xFF and scattered values. On each fetch, the bus model drives the stored byte only while the read strobe is low, 0xFF while the address strobe is low, and a pattern-dependent junk value at all other times. A wrong sampling edge therefore yields junk rather than the expected byte. Each output is compared against the phase boundaries derived arithmetically from `STROBE_W`, `GAP_W` and the synchroniser depth in every cycle. This separates off-by-one strobe or gap lengths from early or late valid and reset release. A sweep then aborts the sequence with a raw reset at every cycle offset and follows each abort with a full fetch, which shows whether any state fails to return to the reset values or to restart cleanly.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE_RESET  = 3'd0,
        ST_ADDR_STROBE = 3'd1,
        ST_ADDR_HOLD   = 3'd2,
        ST_DATA_STROBE = 3'd3,
        ST_DATA_SAMPLE = 3'd4,
        ST_RELEASE     = 3'd5,
        ST_RUN         = 3'd6
    } cfs_state_e;

    typedef struct packed {
        logic cs_n;
        logic as_n;
        logic rd_n;
        logic cpu_rst_n;
        logic vld;
    } cfs_pins_t;

    // Pin levels that belong to each state; strobes only in the two strobe states.
    function automatic cfs_pins_t cfs_decode(input cfs_state_e s);
        cfs_pins_t p;
        p.cs_n      = 1'b1;
        p.as_n      = 1'b1;
        p.rd_n      = 1'b1;
        p.cpu_rst_n = 1'b0;
        p.vld       = 1'b0;
        unique case (s)
            ST_ADDR_STROBE: begin
                p.cs_n = 1'b0;
                p.as_n = 1'b0;
            end
            ST_DATA_STROBE: begin
                p.cs_n = 1'b0;
                p.rd_n = 1'b0;
            end
            ST_RELEASE: begin
                p.vld = 1'b1;
            end
            ST_RUN: begin
                p.vld       = 1'b1;
                p.cpu_rst_n = 1'b1;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/cfs_rst_sync.sv
module cfs_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n
);
    logic [STAGES-1:0] shift_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= (shift_q << 1) | STAGES'(1);
        end
    end

    assign rst_n = shift_q[STAGES-1];

    initial begin
        stages_param_chk: assert (STAGES >= 1)
            else $error("cfs_rst_sync: STAGES must be at least 1");
    end
endmodule

// File: rtl/cfs_timer.sv
module cfs_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/cfs_capture.sv
module cfs_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grab,
    input  logic          publish,
    input  logic [DW-1:0] bus,
    output logic [DW-1:0] cfg_q
);
    logic [DW-1:0] stage_q;

    // Staging register takes the bus on the last data-strobe edge only.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (grab) begin
            stage_q <= bus;
        end
    end

    // Visible register is loaded one settling cycle later.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (publish) begin
            cfg_q <= stage_q;
        end
    end

    // R5
    grab_publish_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grab && publish));

    // R5
    publish_follows_grab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grab |=> publish);
endmodule

// File: rtl/cfs_fsm.sv
module cfs_fsm
    import cfs_pkg::*;
#(
    parameter int STROBE_W = 4,
    parameter int GAP_W    = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    output cfs_pins_t pins,
    output logic      grab,
    output logic      publish
);
    localparam int SPAN  = (STROBE_W > GAP_W) ? STROBE_W : GAP_W;
    localparam int CNT_W = (SPAN < 2) ? 1 : $clog2(SPAN);

    cfs_state_e       state_q, state_d;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE_RESET:  state_d = ST_ADDR_STROBE;
            ST_ADDR_STROBE: if (tmr_done) state_d = ST_ADDR_HOLD;
            ST_ADDR_HOLD:   if (tmr_done) state_d = ST_DATA_STROBE;
            ST_DATA_STROBE: if (tmr_done) state_d = ST_DATA_SAMPLE;
            ST_DATA_SAMPLE: state_d = ST_RELEASE;
            ST_RELEASE:     state_d = ST_RUN;
            ST_RUN:         state_d = ST_RUN;
            default:        state_d = ST_IDLE_RESET;
        endcase
    end

    // Dwell counter is reloaded on every state change.
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_ADDR_STROBE,
            ST_DATA_STROBE: tmr_val = CNT_W'(STROBE_W - 1);
            ST_ADDR_HOLD:   tmr_val = CNT_W'(GAP_W - 1);
            default:        tmr_val = '0;
        endcase
    end

    cfs_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: decoded from the next state so pins line up with state_q.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins <= cfs_decode(ST_IDLE_RESET);
        end else begin
            pins <= cfs_decode(state_d);
        end
    end

    assign grab    = (state_q == ST_DATA_STROBE) && tmr_done;
    assign publish = (state_q == ST_DATA_SAMPLE);

    initial begin
        widths_param_chk: assert (STROBE_W >= 1 && GAP_W >= 1)
            else $error("cfs_fsm: STROBE_W and GAP_W must be at least 1");
    end

    // R3
    gap_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pins.as_n) |-> pins.rd_n);

    // R4
    data_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pins.rd_n) |-> $past(state_q) == ST_ADDR_HOLD);

    // R2
    addr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pins.as_n) |-> $past(state_q) == ST_IDLE_RESET);

    // R6
    grab_then_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grab |=> (pins.cs_n && !pins.vld));
endmodule

// File: rtl/cfg_fetch_seq.sv
module cfg_fetch_seq
    import cfs_pkg::*;
#(
    parameter int STROBE_W    = 4,
    parameter int GAP_W       = 2,
    parameter int SYNC_STAGES = 2,
    parameter int DW          = 8
) (
    input  logic          clk,
    input  logic          rst_in_n,
    input  logic [DW-1:0] bus_in,
    output logic          cpu_rst_n,
    output logic          rtc_cs_n,
    output logic          rtc_as_n,
    output logic          rtc_rd_n,
    output logic [DW-1:0] cfg_q,
    output logic          cfg_vld
);
    logic      rst_n;
    cfs_pins_t pins;
    logic      grab, publish;

    cfs_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .arst_n (rst_in_n),
        .rst_n  (rst_n)
    );

    cfs_fsm #(.STROBE_W(STROBE_W), .GAP_W(GAP_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins    (pins),
        .grab    (grab),
        .publish (publish)
    );

    cfs_capture #(.DW(DW)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .grab    (grab),
        .publish (publish),
        .bus     (bus_in),
        .cfg_q   (cfg_q)
    );

    assign rtc_cs_n  = pins.cs_n;
    assign rtc_as_n  = pins.as_n;
    assign rtc_rd_n  = pins.rd_n;
    assign cpu_rst_n = pins.cpu_rst_n;
    assign cfg_vld   = pins.vld;

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rtc_as_n && !rtc_rd_n));

    // R10
    strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rtc_as_n || !rtc_rd_n) |-> !rtc_cs_n);

    // R1
    cpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_vld |-> !cpu_rst_n);

    // R7
    vld_leads_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_n) |-> $past(cfg_vld) && $past(!cpu_rst_n));

    // R6
    cfg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_vld |-> cfg_q == '0);

    // R8
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_n |=> cpu_rst_n && rtc_cs_n);

    // R8
    cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_vld && $past(cfg_vld)) |-> $stable(cfg_q));
endmodule

// File: tb/tb_cfg_fetch_seq.sv
`timescale 1ns/1ps
module tb_cfg_fetch_seq;
    localparam int SW    = 3;
    localparam int GW    = 2;
    localparam int SS    = 2;
    localparam int B     = SS + 1;
    localparam int T_SMP = B + 2*SW + GW;
    localparam int T_END = T_SMP + 5;

    logic       clk = 1'b0;
    logic       rst_in_n;
    logic [7:0] bus_in;
    logic       cpu_rst_n, rtc_cs_n, rtc_as_n, rtc_rd_n, cfg_vld;
    logic [7:0] cfg_q;

    int  vecs = 0;
    int  bad  = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    cfg_fetch_seq #(.STROBE_W(SW), .GAP_W(GW), .SYNC_STAGES(SS), .DW(8)) dut (
        .clk       (clk),
        .rst_in_n  (rst_in_n),
        .bus_in    (bus_in),
        .cpu_rst_n (cpu_rst_n),
        .rtc_cs_n  (rtc_cs_n),
        .rtc_as_n  (rtc_as_n),
        .rtc_rd_n  (rtc_rd_n),
        .cfg_q     (cfg_q),
        .cfg_vld   (cfg_vld)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, "cpu_rst_n", 8'(cpu_rst_n), 8'h00);
        chk(req, "rtc_cs_n",  8'(rtc_cs_n),  8'h01);
        chk(req, "rtc_as_n",  8'(rtc_as_n),  8'h01);
        chk(req, "rtc_rd_n",  8'(rtc_rd_n),  8'h01);
        chk(req, "cfg_vld",   8'(cfg_vld),   8'h00);
        chk(req, "cfg_q",     cfg_q,         8'h00);
    endtask

    // Release reset and follow the fetch cycle by cycle; abort_at > 0 pulls reset at that cycle.
    task automatic run_seq(input logic [7:0] pat, input int abort_at);
        logic [6:0] rtc_addr;
        rtc_addr = 7'h00;
        @(negedge clk);
        bus_in   = pat ^ 8'h3C;
        rst_in_n = 1'b1;
        for (int c = 1; c <= T_END; c++) begin
            bit    adr, hold, dat, smp, rel, run;
            string req;
            @(posedge clk);
            #3;
            adr  = (c >= B) && (c < B + SW);
            hold = (c >= B + SW) && (c < B + SW + GW);
            dat  = (c >= B + SW + GW) && (c < T_SMP);
            smp  = (c == T_SMP);
            rel  = (c == T_SMP + 1);
            run  = (c >= T_SMP + 2);
            if (adr)       req = "R2";
            else if (hold) req = "R3";
            else if (dat)  req = "R4";
            else if (smp)  req = "R6";
            else if (rel)  req = "R7";
            else if (run)  req = "R8";
            else           req = "R1";
            chk(req, "rtc_cs_n",  8'(rtc_cs_n),  8'(!(adr || dat)));
            chk(req, "rtc_as_n",  8'(rtc_as_n),  8'(!adr));
            chk(req, "rtc_rd_n",  8'(rtc_rd_n),  8'(!dat));
            chk(req, "cpu_rst_n", 8'(cpu_rst_n), 8'(run));
            chk(req, "cfg_vld",   8'(cfg_vld),   8'(rel || run));
            chk((rel || run) ? "R5" : "R6", "cfg_q", cfg_q, (rel || run) ? pat : 8'h00);
            chk("R10", "as_n|rd_n", 8'(rtc_as_n | rtc_rd_n), 8'h01);
            if (c == abort_at) begin
                rst_in_n = 1'b0;
                #1;
                chk_idle("R9");
                return;
            end
            // RTC model: idle bus is 0xFF while the address strobe is low.
            if (!rtc_as_n) begin
                bus_in   = 8'hFF;
                rtc_addr = bus_in[6:0];
            end else if (!rtc_rd_n) begin
                bus_in = (rtc_addr == 7'h7F) ? pat : ~pat;
            end else begin
                bus_in = pat ^ 8'h3C ^ 8'(c);
            end
        end
        chk("R2", "latched address", 8'(rtc_addr), 8'h7F);
        chk("R5", "cfg_q after fetch", cfg_q, pat);
    endtask

    function automatic logic [7:0] pat_of(input int p);
        if (p == 0) return 8'h00;
        if (p == 1) return 8'hFF;
        return 8'(p * 8'h3B) ^ 8'h5A;
    endfunction

    initial begin
        rst_in_n = 1'b0;
        bus_in   = 8'hFF;
        repeat (3) @(negedge clk);
        chk_idle("R1");

        for (int p = 0; p < 16; p++) begin
            run_seq(pat_of(p), 0);
            @(negedge clk);
            rst_in_n = 1'b0;
            #1;
            chk_idle("R9");
            repeat (2) @(negedge clk);
        end

        for (int k = 1; k < T_END; k++) begin
            run_seq(8'hC3 ^ 8'(k), k);
            repeat (2) @(negedge clk);
            run_seq(8'h5A + 8'(k), 0);
            @(negedge clk);
            rst_in_n = 1'b0;
            #1;
            chk_idle("R9");
            repeat (2) @(negedge clk);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end
endmodule